// File: doc/BRIEF.md
# Dual-Modulus 8/9 Clock Prescaler

This block divides a fast input clock by either 8 or 9, chosen by a select input. It is the first stage of a programmable feedback divider: the counters that follow run on its output and change the select to set the overall ratio. Internally a small core of two flip-flops in a loop divides by four. A third flip-flop can hold that loop for one extra cycle, so the core divides by five. A final toggle stage halves the core output and tells the core, for each half of the output period, whether to insert the extra cycle.

With divide-by-8 chosen, both halves of the output period last four input cycles. With divide-by-9 chosen, the high half lasts four cycles and the low half lasts five. The select is taken in only at the start of an output period, on the clock edge where the output rises. Every period therefore runs at one ratio, whatever the select does in between.

Top module: `dual_mod_prescaler`

## Requirements
- R1: A synchronous active-low reset drives `clk_div` low on the next rising edge of `clk_in`. After reset is released, `clk_div` first rises on the 4th rising edge of `clk_in`.
- R2: While `sel_div8` is 1 when a period starts, that output period is 8 input cycles long, with `clk_div` high for 4 cycles and low for 4.
- R3: While `sel_div8` is 0 when a period starts, that output period is 9 input cycles long, with `clk_div` high for 4 cycles and low for 5.
- R4: `sel_div8` is sampled only on the `clk_in` edge where `clk_div` goes from 0 to 1. Its value at that edge sets the length of the low half that follows. Changes at any other time have no effect on the current period.
- R5: The core inserts at most one extra cycle per output period, and it does so only while `clk_div` is low. The high half is always exactly 4 cycles.
- R6: A reset asserted during operation, including while `clk_div` is high, forces `clk_div` low on the next edge. The sequence then restarts as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_div8 | input | 1 | 1 selects divide-by-8, 0 selects divide-by-9 |
| clk_div | output | 1 | Divided clock, driven straight from a flip-flop |

## Verification
Two things can fall in the same cycle here. The first is a select change that arrives exactly on the edge where the output rises, which is when the new ratio is latched. The second is a reset that lands while the extra core cycle is pending. The bench drives the select from a pseudo-random sequence that changes it on nearly every cycle, so both cases occur: a change on the latching edge and a change in the middle of a period. It then judges each output sample against a model that reads the select only at period starts. A reset is also forced while the output is high, and the output must be low on the next edge and restart with the four-cycle lead-in.

// File: rtl/prescaler_pkg.sv
// Shared constants for the dual-modulus prescaler.
// Assumes: the core is a two-flip-flop loop whose base ratio is 4.
package prescaler_pkg;
    localparam int CORE_BASE   = 4;              // core ratio without stretch
    localparam int HIGH_CYCLES = CORE_BASE;      // high half of every period
    localparam int RUN_W       = 4;              // width of run-length counters
endpackage

// File: rtl/pscl_core.sv
// Divide-by-4/5 core: a two-flip-flop Johnson loop plus one stretch flip-flop.
// Sequence of {loop_a, loop_b}: 00,10,11,01. The state 01 is the wrap cycle.
// When stretch_en is high during wrap, the stretch flip-flop holds the loop
// at 00 for one extra cycle, giving a core period of 5.
// Assumes stretch_en is synchronous to clk.
module pscl_core (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_en,
    output logic wrap,
    output logic stretch
);
    logic loop_a, loop_b;

    // Wrap is the last cycle of a core period.
    assign wrap = ~loop_a & loop_b;

    // Loop update; the stretch bit is ORed into the first stage's feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_a  <= 1'b0;
            loop_b  <= 1'b0;
            stretch <= 1'b0;
        end else begin
            loop_a  <= ~(loop_b | stretch);
            loop_b  <= loop_a;
            stretch <= wrap & stretch_en;
        end
    end
endmodule

// File: rtl/pscl_toggle.sv
// Output halving stage and ratio control.
// Toggles the output at each core wrap. The select is latched when the output
// is about to rise, which is a period boundary. The stretch is requested for
// the core period that follows the high half, i.e. the low half.
// Assumes wrap is a single-cycle pulse from pscl_core.
module pscl_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic sel_div8,
    output logic out_q,
    output logic stretch_en
);
    logic odd_mode;

    // A stretch is wanted only in odd mode, at the wrap that ends the high half.
    assign stretch_en = odd_mode & out_q;

    // Output toggle and boundary-latched mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            odd_mode <= ~sel_div8;
        end else begin
            out_q <= out_q ^ wrap;
            if (wrap && !out_q)
                odd_mode <= ~sel_div8;
        end
    end
endmodule

// File: rtl/dual_mod_prescaler.sv
// Top: dual-modulus 8/9 prescaler built from a 4/5 core and a toggle stage.
// Assumes a single clock domain and a synchronous active-low reset.
module dual_mod_prescaler (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel_div8,
    output logic clk_div
);
    logic core_wrap;
    logic core_stretch;
    logic stretch_req;

    pscl_core u_core (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .stretch_en (stretch_req),
        .wrap       (core_wrap),
        .stretch    (core_stretch)
    );

    pscl_toggle u_tog (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .wrap       (core_wrap),
        .sel_div8   (sel_div8),
        .out_q      (clk_div),
        .stretch_en (stretch_req)
    );
endmodule

// File: rtl/prescaler_chk.sv
// Checker for dual_mod_prescaler. It measures run lengths of clk_div and
// relates them to the select seen at each period start.
module prescaler_chk
    import prescaler_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sel_div8,
    input logic clk_div,
    input logic stretch
);
    logic             prev_out;
    logic [RUN_W-1:0] run;
    logic             sel_d;
    logic             mode8_cur;
    logic             started;
    logic             rise_seen;
    logic             fall_seen;

    assign rise_seen = clk_div & ~prev_out;
    assign fall_seen = ~clk_div & prev_out;

    // Track the run length, the select one edge back, and the latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_out  <= 1'b0;
            run       <= '0;
            sel_d     <= 1'b0;
            mode8_cur <= 1'b0;
            started   <= 1'b0;
        end else begin
            prev_out <= clk_div;
            run      <= (clk_div != prev_out) ? RUN_W'(1) : run + RUN_W'(1);
            sel_d    <= sel_div8;
            if (rise_seen) begin
                mode8_cur <= sel_d;
                started   <= 1'b1;
            end
        end
    end

    // R5
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |-> run == RUN_W'(HIGH_CYCLES));

    // R2 R3 R4
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_seen && started) |-> run == (mode8_cur ? RUN_W'(4) : RUN_W'(5)));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_W'(5));

    // R5
    stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> !clk_div);

    // R5
    stretch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> !stretch);
endmodule

bind dual_mod_prescaler prescaler_chk u_chk (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .sel_div8 (sel_div8),
    .clk_div  (clk_div),
    .stretch  (core_stretch)
);

// File: tb/tb_dual_mod_prescaler.sv
module tb_dual_mod_prescaler;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic sel   = 1'b1;
    logic clk_div;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R1";
    bit    finished = 1'b0;

    bit exp_out = 1'b0;
    int rem = 4;
    bit m9 = 1'b0;

    dual_mod_prescaler dut (
        .clk_in   (clk_in_w),
        .rst_n    (rst_n),
        .sel_div8 (sel),
        .clk_div  (clk_div)
    );
    wire clk_in_w = clk;

    // Reference: remaining-cycles countdown; select read only at a rise.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_out = 1'b0;
            rem     = 4;
            m9      = !sel;
        end else begin
            rem = rem - 1;
            if (rem == 0) begin
                if (!exp_out) begin
                    exp_out = 1'b1;
                    m9      = !sel;
                    rem     = 4;
                end else begin
                    exp_out = 1'b0;
                    rem     = m9 ? 5 : 4;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (clk_div !== exp_out) begin
                n_bad++;
                $display("FAIL %s: clk_div=%0b expected %0b at %0t", tag, clk_div, exp_out, $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R1: reset state and lead-in to the first rise
        tag = "R1";
        cycles(3);
        rst_n = 1'b1;
        cycles(12);
        // R2: divide-by-8
        tag = "R2";
        sel = 1'b1;
        cycles(40);
        // R3: divide-by-9
        tag = "R3";
        sel = 1'b0;
        cycles(54);
        // R4: select changing on arbitrary cycles, including on the latching edge
        tag = "R4";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel  = lfsr[0];
            cycles(1);
        end
        // R6: reset while the output is high
        tag = "R6";
        sel = 1'b0;
        while (clk_div !== 1'b1) cycles(1);
        rst_n = 1'b0;
        cycles(1);
        n_cmp++;
        if (clk_div !== 1'b0) begin
            n_bad++;
            $display("FAIL R6: clk_div=%0b expected 0 after reset edge", clk_div);
        end
        cycles(1);
        rst_n = 1'b1;
        cycles(20);
        // R5: odd mode, high half stays 4 and stretch only in low half
        tag = "R5";
        sel = 1'b0;
        cycles(30);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected end before 5000 cycles");
            summary();
            $finish;
        end
    end
endmodule